// File: doc/BRIEF.md
# SMBus DAC Register Slave

This block is a two-wire serial slave that gives a bus master write and read access to the two control registers of an 8-bit DAC. It watches the open-drain clock and data lines and brings both into the fast system clock domain through a synchroniser. After that it recognises bus start and stop events, checks the fixed 7-bit device address and acknowledges each accepted byte. It can pull the data line low only through an output-enable.

Every access begins with a write phase. The byte after the address is a command byte that picks a register. Further bytes in that same write phase land in the chosen register. To read, the master issues a repeated start with the read bit set, and the block shifts out the chosen register. The register contents drive the DAC code and configuration outputs directly.

Top module: `dac_ctl_slave`

## Requirements
- R1: After reset, `dac_o` and `cfg_o` are 0x00 and `sda_oe_o` is 0.
- R2: Until a START occurs (SDA falls while SCL is high), bus clocking has no effect: `sda_oe_o` stays 0 and no register changes.
- R3: The first byte after START holds a 7-bit address followed by a read/write bit, MSB first, where 1 means read. For address 1001000 the block pulls SDA low during the ninth clock. For any other address SDA stays released until the next START.
- R4: In a write (bit 0 of the address byte = 0), the byte after the address is a command byte. Command 0x00 selects the DAC register and 0x01 selects the configuration register. The next byte, sampled on SCL rising edges with the MSB first, is stored in the selected register. The command byte and the data byte are each acknowledged.
- R5: A data byte written after any other command value is acknowledged, but neither register changes.
- R6: Further data bytes in the same write phase are each acknowledged and stored in the same selected register, so the last byte wins.
- R7: After a repeated START with the address and read bit 1, the block drives the selected register MSB first on the next eight clocks, then releases SDA. If the master acknowledges, the same register is sent again. If the master does not acknowledge, SDA stays released.
- R8: A STOP (SDA rises while SCL is high) returns the block to idle from any point. A partly received byte is discarded and causes no write.
- R9: `sda_oe_o` only changes while the synchronised SCL is low, so the block never creates a START or STOP of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low |
| dac_o | output | 8 | DAC code register |
| cfg_o | output | 8 | Configuration register |

## Verification
The bench builds the block with its default parameters: address 1001000, a two-stage synchroniser and 8-bit registers. With these defaults both mapped command values and an unmapped one (0x07) can be reached, as well as a neighbouring address that must be refused. The two-stage synchroniser sets a latency of a few system clocks between an SCL edge and the output-enable, and the bench's quarter-bit spacing of six clocks keeps that latency inside each SCL low phase. This is what lets R9 be checked on the master's own SCL.

// File: rtl/dac_ctl_pkg.sv
package dac_ctl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK, ST_WAIT
  } bus_st_e;

  localparam logic [6:0] DEF_DEV_ADDR = 7'b1001000;
endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] raw, synced, prev_q;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;  // idle bus is high
      else         chain_q <= {chain_q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= synced;
  end

  assign scl_o      = synced[1];
  assign sda_o      = synced[0];
  assign scl_rise_o = synced[1] & ~prev_q[1];
  assign scl_fall_o = ~synced[1] & prev_q[1];
  // SDA edge with SCL held high on both samples
  assign start_o    = synced[1] & prev_q[1] & prev_q[0] & ~synced[0];
  assign stop_o     = synced[1] & prev_q[1] & ~prev_q[0] & synced[0];
endmodule

// File: rtl/sbus_engine.sv
module sbus_engine
  import dac_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = DEF_DEV_ADDR,
  parameter int         BYTE_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [BYTE_W-1:0] ptr_o,
  output bus_st_e           state_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  bus_st_e           state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, ptr_q;
  logic              oe_q, rd_mode_q, mack_q, wr_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      ptr_q     <= '0;
      oe_q      <= 1'b0;
      rd_mode_q <= 1'b0;
      mack_q    <= 1'b0;
      wr_en_q   <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_s_i};
              cnt_q <= cnt_q + CNT_ONE;
            end else if (scl_fall_i && cnt_q == CNT_FULL) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  oe_q      <= 1'b1;
                  rd_mode_q <= sh_q[0];
                  state_q   <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_WAIT;
                end
              end else if (state_q == ST_CMD) begin
                ptr_q   <= sh_q;
                oe_q    <= 1'b1;
                state_q <= ST_CMD_ACK;
              end else begin
                wr_en_q <= 1'b1;
                oe_q    <= 1'b1;
                state_q <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: begin
            if (scl_rise_i) begin
              cnt_q <= CNT_ONE;
            end else if (scl_fall_i && cnt_q == CNT_ONE) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR_ACK && rd_mode_q) begin
                sh_q    <= rd_data_i;
                oe_q    <= ~rd_data_i[BYTE_W-1];
                state_q <= ST_RDATA;
              end else begin
                oe_q    <= 1'b0;
                state_q <= (state_q == ST_ADDR_ACK) ? ST_CMD : ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + CNT_ONE;
            end else if (scl_fall_i) begin
              if (cnt_q == CNT_FULL) begin
                cnt_q   <= '0;
                oe_q    <= 1'b0;
                state_q <= ST_RACK;
              end else begin
                sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
                oe_q <= ~sh_q[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              cnt_q  <= CNT_ONE;
              mack_q <= ~sda_s_i;
            end else if (scl_fall_i && cnt_q == CNT_ONE) begin
              cnt_q <= '0;
              if (mack_q) begin
                sh_q    <= rd_data_i;
                oe_q    <= ~rd_data_i[BYTE_W-1];
                state_q <= ST_RDATA;
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          default: ;  // idle / wait: only start or stop matter
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = wr_en_q;
  assign wr_data_o = sh_q;
  assign ptr_o     = ptr_q;
  assign state_o   = state_q;
endmodule

// File: rtl/dac_regfile.sv
module dac_regfile #(
  parameter int NUM_REGS = 2,
  parameter int REG_W    = 8,
  parameter int PTR_W    = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [PTR_W-1:0]          ptr_i,
  input  logic [REG_W-1:0]          wr_data_i,
  output logic [NUM_REGS*REG_W-1:0] regs_o,
  output logic [REG_W-1:0]          rd_data_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [REG_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              r_q <= '0;
      else if (wr_en_i && ptr_i == PTR_W'(i))   r_q <= wr_data_i;
    end
    assign regs_o[i*REG_W +: REG_W] = r_q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (ptr_i == PTR_W'(i)) rd_data_o = regs_o[i*REG_W +: REG_W];
  end
endmodule

// File: rtl/dac_ctl_slave.sv
module dac_ctl_slave
  import dac_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = DEF_DEV_ADDR,
  parameter int         SYNC_STAGES = 2,
  parameter int         REG_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic [REG_W-1:0] dac_o,
  output logic [REG_W-1:0] cfg_o
);
  localparam int NUM_REGS = 2;

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic wr_en;
  logic [REG_W-1:0] wr_data, ptr, rd_data;
  logic [NUM_REGS*REG_W-1:0] regs;
  bus_st_e state;

  sbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop)
  );

  sbus_engine #(.DEV_ADDR(DEV_ADDR), .BYTE_W(REG_W)) u_engine (
    .clk_i, .rst_ni, .sda_s_i(sda_s), .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop),
    .rd_data_i(rd_data), .sda_oe_o, .wr_en_o(wr_en),
    .wr_data_o(wr_data), .ptr_o(ptr), .state_o(state)
  );

  dac_regfile #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .PTR_W(REG_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .ptr_i(ptr), .wr_data_i(wr_data),
    .regs_o(regs), .rd_data_o(rd_data)
  );

  assign dac_o = regs[0 +: REG_W];
  assign cfg_o = regs[REG_W +: REG_W];
endmodule

// File: rtl/dac_ctl_slave_chk.sv
module dac_ctl_slave_chk
  import dac_ctl_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s,
  input logic       start,
  input logic       stop,
  input bus_st_e    state,
  input logic       sda_oe_o,
  input logic [7:0] dac_o,
  input logic [7:0] cfg_o
);
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_s)); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IDLE |-> !sda_oe_o); // R2
  AST_MISMATCH_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_WAIT |-> !sda_oe_o); // R3
  AST_START_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> state == ST_ADDR); // R3
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (state == ST_IDLE && !sda_oe_o)); // R8
  AST_DAC_WRITE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dac_o) |-> $past(state) == ST_WDATA_ACK); // R4
  AST_CFG_WRITE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> $past(state) == ST_WDATA_ACK); // R5
endmodule

bind dac_ctl_slave dac_ctl_slave_chk u_chk (.*);

// File: tb/dac_ctl_slave_tb_top.sv
module dac_ctl_slave_tb_top;
  localparam int Q = 6;  // quarter bit, in system clocks
  localparam int NV = 6;
  // {address byte, command, data, expected address ack}
  localparam logic [24:0] VEC [NV] = '{
    {8'h90, 8'h00, 8'hA5, 1'b1},
    {8'h90, 8'h01, 8'h3C, 1'b1},
    {8'h92, 8'h00, 8'hFF, 1'b0},
    {8'h90, 8'h07, 8'h77, 1'b1},
    {8'h90, 8'h00, 8'h00, 1'b1},
    {8'h90, 8'h01, 8'hFF, 1'b1}
  };

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  logic sda_oe;
  logic [7:0] dac, cfg;
  wire sda_bus = sda_m & ~sda_oe;
  int errors = 0, checks = 0, oe_bad = 0, oe_seen = 0;
  bit done = 0;
  logic [7:0] m_dac = 0, m_cfg = 0;

  always #2 clk = ~clk;

  dac_ctl_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .dac_o(dac), .cfg_o(cfg)
  );

  logic oe_d = 0;
  always @(posedge clk) begin
    if (sda_oe !== oe_d && scl_m) oe_bad++;
    if (sda_oe) oe_seen++;
    oe_d <= sda_oe;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(posedge clk); #1; endtask

  task automatic bus_start();
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0;
  endtask

  task automatic bus_stop();
    wq(); sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq();
  endtask

  task automatic send_bit(input logic b);
    wq(); sda_m = b; wq(); scl_m = 1; wq(); wq(); scl_m = 0;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1; wq(); wq(); scl_m = 1; wq(); ack = ~sda_bus; wq(); scl_m = 0;
  endtask

  task automatic rd_byte(output logic [7:0] b, input logic mack);
    sda_m = 1; b = 0;
    for (int i = 0; i < 8; i++) begin
      wq(); wq(); scl_m = 1; wq(); b = {b[6:0], sda_bus}; wq(); scl_m = 0;
    end
    wq(); sda_m = ~mack; wq(); scl_m = 1; wq(); wq(); scl_m = 0;
  endtask

  task automatic read_reg(input logic [7:0] cmd, output logic [7:0] v);
    logic a;
    bus_start(); wr_byte(8'h90, a); wr_byte(cmd, a);
    bus_start(); wr_byte(8'h91, a); rd_byte(v, 1'b0); bus_stop();
  endtask

  initial begin
    logic a, a2, a3;
    logic [7:0] v, v2;
    repeat (5) @(posedge clk); #1;
    chk("R1 oe", {7'b0, sda_oe}, 8'h00);
    chk("R1 dac", dac, 8'h00);
    chk("R1 cfg", cfg, 8'h00);
    rst_n = 1; wq();

    // R2: clock a matching address and data with no START
    oe_seen = 0;
    for (int i = 7; i >= 0; i--) send_bit(8'h90 >> i);
    send_bit(1'b1);
    for (int i = 7; i >= 0; i--) send_bit(8'hA5 >> i);
    send_bit(1'b1);
    scl_m = 1; wq();
    chk("R2 no drive", oe_seen[7:0], 8'h00);
    chk("R2 dac untouched", dac, 8'h00);

    for (int k = 0; k < NV; k++) begin
      logic [7:0] ab, cm, dt;
      logic ea;
      {ab, cm, dt, ea} = VEC[k];
      bus_start(); wr_byte(ab, a);
      chk("R3 address ack", {7'b0, a}, {7'b0, ea});
      if (ea) begin
        wr_byte(cm, a2); wr_byte(dt, a3);
        chk("R4 command ack", {7'b0, a2}, 8'h01);
        chk(cm > 1 ? "R5 data ack" : "R4 data ack", {7'b0, a3}, 8'h01);
        if (cm == 0) m_dac = dt;
        if (cm == 1) m_cfg = dt;
      end
      bus_stop();
      chk(cm > 1 ? "R5 dac" : "R4 dac", dac, m_dac);
      chk(cm > 1 ? "R5 cfg" : "R4 cfg", cfg, m_cfg);
      if (cm < 2) begin
        read_reg(cm, v);
        chk("R7 readback", v, cm == 0 ? m_dac : m_cfg);
      end
    end

    // R6: two data bytes in one write phase
    bus_start(); wr_byte(8'h90, a); wr_byte(8'h01, a);
    wr_byte(8'h11, a2); wr_byte(8'h6E, a3); bus_stop();
    m_cfg = 8'h6E;
    chk("R6 second ack", {7'b0, a3}, 8'h01);
    chk("R6 last wins", cfg, 8'h6E);

    // R7: master ACK gets the register twice, then NACK releases
    bus_start(); wr_byte(8'h90, a); wr_byte(8'h00, a);
    bus_start(); wr_byte(8'h91, a);
    rd_byte(v, 1'b1); rd_byte(v2, 1'b0);
    wq(); wq();
    chk("R7 first copy", v, m_dac);
    chk("R7 second copy", v2, m_dac);
    chk("R7 released after nack", {7'b0, sda_oe}, 8'h00);
    bus_stop();

    // R8: STOP in the middle of a data byte discards it
    bus_start(); wr_byte(8'h90, a); wr_byte(8'h00, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    chk("R8 partial byte dropped", dac, m_dac);
    bus_start(); wr_byte(8'h90, a); wr_byte(8'h00, a); wr_byte(8'h5A, a2); bus_stop();
    m_dac = 8'h5A;
    chk("R8 recovers after stop", dac, 8'h5A);

    // R3: after mismatch, following bytes draw no ack
    bus_start(); wr_byte(8'h20, a); wr_byte(8'h00, a2); bus_stop();
    chk("R3 no ack mismatch", {6'b0, a, a2}, 8'h00);

    chk("R9 oe only with scl low", oe_bad[7:0], 8'h00);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule